// File: doc/BRIEF.md
# In-order destination scoreboard with dual hazard search

This block tracks the destination registers of instructions that have left the issue point of an in-order pipeline and have not yet committed. Each dispatched instruction inserts one entry at the tail, whether or not it writes a register. An instruction with no destination still takes a slot, but its entry is marked invalid. When an instruction commits, the oldest entry is removed from the head. Commits happen in order, so no other entry ever leaves first.

The issue logic presents the two source operands of the next instruction to two independent search ports. Each port answers in the same cycle whether an older, still-pending instruction will write that register. A hit means a read-after-write hazard, and the issue stage holds the instruction until the hit clears.

A parameter selects the ordering within a cycle. In the pipeline ordering, a remove in the current cycle is applied before the searches and before the insert. An instruction that commits this cycle therefore causes no stall. A full scoreboard can also accept a new entry in the same cycle that it retires one.

Top module: `raw_scoreboard`

## Requirements
- R1: After reset the block reports empty=1, full=0, err=0, and no hit on either search port.
- R2: An accepted insert takes one slot whether its destination is valid or invalid. After DEPTH net inserts, full=1 and empty=0.
- R3: A remove always retires the oldest remaining entry, so entries leave in the order they were inserted.
- R4: A search port reports a hit only when its source valid bit is 1 and some occupied entry is valid and holds an equal index. Invalid entries never match.
- R5: The two search ports are independent, and both can report a hit in the same cycle.
- R6: With REMOVE_FIRST=1, the oldest entry is hidden from both searches during a cycle in which rem_en is high and the block is not empty.
- R7: With REMOVE_FIRST=1, when the block is full, an insert together with a remove in the same cycle is accepted. The block stays full, and the new entry becomes searchable from the next cycle.
- R8: When several entries hold the same valid index, a search for that index hits for as long as at least one of them remains.
- R9: An insert while full, without an accepted remove in the same cycle, is dropped. err is 1 in the following cycle, and the dropped index never produces a hit.
- R10: A remove while empty is ignored. err is 1 in the following cycle and empty stays 1.
- R11: An insert is not visible to the searches in the cycle in which it is presented. It becomes visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_en | input | 1 | Insert request (dispatch) |
| ins_vld | input | 1 | Inserted destination is valid |
| ins_idx | input | IDX_W | Inserted destination register index |
| rem_en | input | 1 | Remove oldest entry (commit) |
| src_a_vld | input | 1 | Search port A source is valid |
| src_a_idx | input | IDX_W | Search port A source index |
| src_b_vld | input | 1 | Search port B source is valid |
| src_b_idx | input | IDX_W | Search port B source index |
| hit_a | output | 1 | Port A matches a pending destination |
| hit_b | output | 1 | Port B matches a pending destination |
| full | output | 1 | All DEPTH slots occupied |
| empty | output | 1 | No slot occupied |
| err | output | 1 | A request was ignored in the previous cycle |

## Verification
The assertions assume that ins_en and rem_en are sampled as clean levels at each rising edge. They also assume that the error flag is judged against the full and empty flags seen in the same cycle as the request. The stimulus changes inputs only on falling edges and holds every request for exactly one cycle, so each request meets one rising edge. The stimulus also deliberately sends inserts while full and removes while empty, so that the ignored-request paths are exercised and never assumed away.

// File: rtl/raw_scoreboard.sv
module raw_scoreboard #(
  parameter int DEPTH = 4,
  parameter int IDX_W = 5,
  parameter bit REMOVE_FIRST = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_en,
  input  logic             ins_vld,
  input  logic [IDX_W-1:0] ins_idx,
  input  logic             rem_en,
  input  logic             src_a_vld,
  input  logic [IDX_W-1:0] src_a_idx,
  input  logic             src_b_vld,
  input  logic [IDX_W-1:0] src_b_idx,
  output logic             hit_a,
  output logic             hit_b,
  output logic             full,
  output logic             empty,
  output logic             err
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [IDX_W-1:0] idx_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;
  logic             err_q;
  logic [DEPTH-1:0] live, match_a, match_b;
  logic             rem_ok, ins_ok, skip;

  assign full   = cnt_q == CNT_W'(DEPTH);
  assign empty  = cnt_q == '0;
  assign err    = err_q;
  assign rem_ok = rem_en && !empty;
  assign ins_ok = ins_en && (!full || (REMOVE_FIRST && rem_ok));
  assign skip   = REMOVE_FIRST && rem_ok;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    live = '0;
    for (int k = 0; k < DEPTH; k++) begin
      int s;
      s = int'(head_q) + k;
      if (s >= DEPTH) s = s - DEPTH;
      if (k >= int'(skip) && k < int'(cnt_q)) live[s] = 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign match_a[i] = live[i] && vld_q[i] && src_a_vld && (idx_q[i] == src_a_idx);
    assign match_b[i] = live[i] && vld_q[i] && src_b_vld && (idx_q[i] == src_b_idx);
  end

  assign hit_a = |match_a;
  assign hit_b = |match_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      err_q  <= 1'b0;
      vld_q  <= '0;
    end else begin
      if (rem_ok) head_q <= bump(head_q);
      if (ins_ok) begin
        tail_q        <= bump(tail_q);
        vld_q[tail_q] <= ins_vld;
      end
      cnt_q <= cnt_q + CNT_W'(ins_ok) - CNT_W'(rem_ok);
      err_q <= (ins_en && !ins_ok) || (rem_en && !rem_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (ins_ok) idx_q[tail_q] <= ins_idx;
  end

  AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> empty && !full && !err); // R1
  AST_EMPTY_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n) empty |-> !hit_a && !hit_b); // R4
  AST_INVALID_SRC: assert property (@(posedge clk) disable iff (!rst_n) !src_a_vld |-> !hit_a); // R4
  AST_FILL: assert property (@(posedge clk) disable iff (!rst_n) (ins_en && !rem_en && !full) |=> !empty); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (ins_en && full && !rem_en) |=> err && full); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (rem_en && empty && !ins_en) |=> err && empty); // R10
  AST_SWAP_FULL: assert property (@(posedge clk) disable iff (!rst_n) (REMOVE_FIRST && full && ins_en && rem_en) |=> full && !err); // R7
endmodule

// File: tb/raw_scoreboard_tb.sv
`timescale 1ns/1ps
module raw_scoreboard_tb;
  localparam int DEPTH = 4;
  localparam int IDX_W = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_en = 0, ins_vld = 0, rem_en = 0, src_a_vld = 0, src_b_vld = 0;
  logic [IDX_W-1:0] ins_idx = '0, src_a_idx = '0, src_b_idx = '0;
  logic hit_a, hit_b, full, empty, err;

  always #2.5 clk = ~clk;

  raw_scoreboard #(.DEPTH(DEPTH), .IDX_W(IDX_W), .REMOVE_FIRST(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .ins_en(ins_en), .ins_vld(ins_vld), .ins_idx(ins_idx),
    .rem_en(rem_en), .src_a_vld(src_a_vld), .src_a_idx(src_a_idx),
    .src_b_vld(src_b_vld), .src_b_idx(src_b_idx),
    .hit_a(hit_a), .hit_b(hit_b), .full(full), .empty(empty), .err(err));

  int checks = 0, fails = 0;
  bit done = 0;
  bit m_v[$];
  logic [IDX_W-1:0] m_i[$];
  bit m_err = 0;
  logic [4:0] exp_q[$];
  string tag_q[$];
  event ev;

  function automatic bit model_hit(bit vld, logic [IDX_W-1:0] idx, int skip);
    for (int k = skip; k < m_v.size(); k++)
      if (vld && m_v[k] && m_i[k] == idx) return 1'b1;
    return 1'b0;
  endfunction

  task automatic step(bit ie, bit iv, int ii, bit re, bit av, int ai, bit bv, int bi, string tag);
    int skip;
    bit rem_ok, ins_ok;
    @(negedge clk);
    ins_en = ie; ins_vld = iv; ins_idx = IDX_W'(ii); rem_en = re;
    src_a_vld = av; src_a_idx = IDX_W'(ai); src_b_vld = bv; src_b_idx = IDX_W'(bi);
    skip = (re && m_v.size() > 0) ? 1 : 0;
    exp_q.push_back({model_hit(av, IDX_W'(ai), skip), model_hit(bv, IDX_W'(bi), skip),
                     m_v.size() == DEPTH, m_v.size() == 0, m_err});
    tag_q.push_back(tag);
    -> ev;
    @(posedge clk);
    rem_ok = re && m_v.size() > 0;
    ins_ok = ie && (m_v.size() < DEPTH || rem_ok);
    m_err = (ie && !ins_ok) || (re && !rem_ok);
    if (rem_ok) begin void'(m_v.pop_front()); void'(m_i.pop_front()); end
    if (ins_ok) begin m_v.push_back(iv); m_i.push_back(IDX_W'(ii)); end
  endtask

  initial begin : monitor
    forever begin
      logic [4:0] e, a;
      string t;
      @(ev);
      #1;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {hit_a, hit_b, full, empty, err};
      checks++;
      if (a !== e) begin
        fails++;
        $display("FAIL %s: {hit_a,hit_b,full,empty,err} actual %b expected %b", t, a, e);
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(0,0,0, 0, 1,3, 1,3, "R1 reset state");
    step(1,1,3, 0, 1,3, 0,0, "R11 insert not yet visible");
    step(0,0,0, 0, 1,3, 1,3, "R5 both ports hit");
    step(1,0,0, 0, 1,0, 0,3, "R4 invalid source");
    step(0,0,0, 0, 1,0, 1,3, "R4 invalid entry never matches");
    step(1,1,7, 0, 1,7, 1,3, "R11 same-cycle insert hidden");
    step(1,1,3, 0, 1,7, 1,2, "R2 fill to full");
    step(1,1,9, 0, 1,9, 1,3, "R2 full flag set");
    step(0,0,0, 0, 1,9, 1,7, "R9 dropped insert and err");
    step(1,1,3, 1, 1,3, 1,3, "R8 duplicate keeps hit while head retires");
    step(0,0,0, 0, 1,3, 1,7, "R3 oldest entry removed");
    step(1,1,6, 1, 1,7, 1,6, "R7 full swap accepted");
    step(0,0,0, 0, 1,6, 1,7, "R7 new entry visible");
    step(0,0,0, 1, 1,7, 1,3, "R6 committing entry hidden");
    step(0,0,0, 1, 1,3, 1,6, "R8 one duplicate left");
    step(0,0,0, 1, 1,3, 1,6, "R3 retire order");
    step(0,0,0, 1, 1,6, 1,3, "R6 last entry hidden");
    step(0,0,0, 1, 1,6, 1,3, "R10 remove while empty");
    step(0,0,0, 0, 1,6, 1,3, "R10 err after empty remove");
    step(0,0,0, 0, 1,6, 1,3, "R1 err clears");
    @(negedge clk);
    #1;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule